// File: doc/BRIEF.md
# Four-Stage Floating-Point Adder Pipeline

This block adds two operands held in a simplified floating-point form. Each operand is a sign bit, an unsigned magnitude read as a binary fraction, and a two's-complement exponent. Its value is the fraction times two to the power of the exponent. The block accepts one operand pair on every clock. Each pair passes through four registered stages, and the sum leaves the last stage as a normalized sign, fraction and exponent.

In the first stage the exponents are compared. The larger exponent is kept, and their distance becomes a shift amount. In the second stage the fraction with the smaller exponent is moved right by that distance, and the two aligned magnitudes are then added or subtracted according to the signs. The third stage counts the leading zeros of the raw result and sorts it into one of three kinds: zero, carry-out, or ordinary. The fourth stage shifts the fraction and adjusts the exponent so that a non-zero result lies in the interval one half up to, but not including, one.

The operand format has no special values, no rounding and no subnormal range. Bits shifted out during alignment or carry correction are discarded.

Top module: `fpadd_pipe`

## Requirements
- R1: A pair presented with `in_valid` high at a rising edge appears with `out_valid` high after the third rising edge that follows, so the latency is four register stages. A new pair can be taken on every edge, and `out_valid` is low four stages after an edge where `in_valid` was low.
- R2: While `rst` is high at a rising edge, the pipeline is emptied, and `out_valid` is low after that edge and stays low until new valid pairs have passed through.
- R3: The result exponent before normalization is the larger of the two input exponents, r. The other operand's magnitude is shifted right by the exponent distance, with the lost bits truncated. A distance equal to or greater than `FRAC_W` makes that aligned magnitude zero. When the exponents are equal, no shift takes place.
- R4: When the two signs are equal, the aligned magnitudes are added and the result takes the common sign.
- R5: When the two signs differ, the smaller aligned magnitude is subtracted from the larger, and the result takes the sign of the larger one.
- R6: When the addition overflows the fraction width, the output fraction is the sum shifted right by one with the low bit dropped, and the output exponent is r + 1.
- R7: A non-zero result with no overflow is shifted left until its fraction MSB (bit `FRAC_W-1`) is set, which means 0.5 <= fraction < 1. The output exponent is r minus the shift.
- R8: A zero result gives sign 0, fraction 0 and exponent 0.
- R9: The output exponent is a two's-complement number `EXP_W+2` bits wide and never wraps. It lies between -(2^(EXP_W-1)) - (FRAC_W-1) and 2^(EXP_W-1).
- R10: The fraction field's value is the magnitude divided by 2^`FRAC_W`. A sign bit of 1 means negative, and the exponent inputs are `EXP_W`-bit two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| a_sign | input | 1 | Sign of operand A (1 = negative) |
| a_frac | input | FRAC_W | Magnitude of operand A |
| a_exp | input | EXP_W | Two's-complement exponent of operand A |
| b_sign | input | 1 | Sign of operand B |
| b_frac | input | FRAC_W | Magnitude of operand B |
| b_exp | input | EXP_W | Two's-complement exponent of operand B |
| out_valid | output | 1 | Result present this cycle |
| out_sign | output | 1 | Sign of the result |
| out_frac | output | FRAC_W | Normalized result magnitude |
| out_exp | output | EXP_W+2 | Two's-complement result exponent |

## Verification
The bench drives every pairing of sign, magnitude and exponent for a 4-bit fraction with a 3-bit exponent as one continuous stream, with idle gaps, and computes each expected sum with integer arithmetic. This reaches the cases a faulty design gets wrong:
- Shift distances of four or more: a shifter that wraps would add back bits that should be gone.
- Equal magnitudes of opposite sign: a design without the zero bypass would leave a stale exponent or a negative zero.
- Carry-outs: omitting the right shift would lose the top bit.
- Unnormalized inputs that need a left shift of up to three places: a wrong leading-zero count would shift too far or not far enough.

A reset asserted while the pipeline is full checks that no stale result escapes.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int STAGES = 4;

  typedef enum logic [1:0] {
    RES_NORM  = 2'd0,
    RES_CARRY = 2'd1,
    RES_ZERO  = 2'd2
  } res_kind_e;
endpackage

// File: rtl/fpadd_cmp.sv
module fpadd_cmp #(
  parameter int FRAC_W = 8,
  parameter int EXP_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              a_sign,
  input  logic [FRAC_W-1:0] a_frac,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic              b_sign,
  input  logic [FRAC_W-1:0] b_frac,
  input  logic [EXP_W-1:0]  b_exp,
  output logic              s1_valid,
  output logic              big_sign,
  output logic [FRAC_W-1:0] big_frac,
  output logic              sml_sign,
  output logic [FRAC_W-1:0] sml_frac,
  output logic [EXP_W-1:0]  exp_r,
  output logic [EXP_W-1:0]  shift_t
);
  logic [EXP_W:0] diff;
  logic [EXP_W:0] diff_neg;
  logic           a_ge;

  always_comb begin
    diff     = {a_exp[EXP_W-1], a_exp} - {b_exp[EXP_W-1], b_exp};
    diff_neg = -diff;
    a_ge     = ~diff[EXP_W];
  end

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
    if (a_ge) begin
      big_sign <= a_sign;
      big_frac <= a_frac;
      sml_sign <= b_sign;
      sml_frac <= b_frac;
      exp_r    <= a_exp;
      shift_t  <= diff[EXP_W-1:0];
    end else begin
      big_sign <= b_sign;
      big_frac <= b_frac;
      sml_sign <= a_sign;
      sml_frac <= a_frac;
      exp_r    <= b_exp;
      shift_t  <= diff_neg[EXP_W-1:0];
    end
  end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
  parameter int FRAC_W = 8,
  parameter int EXP_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  logic              big_sign,
  input  logic [FRAC_W-1:0] big_frac,
  input  logic              sml_sign,
  input  logic [FRAC_W-1:0] sml_frac,
  input  logic [EXP_W-1:0]  exp_r,
  input  logic [EXP_W-1:0]  shift_t,
  output logic              s2_valid,
  output logic              c_sign,
  output logic [FRAC_W:0]   c_mag,
  output logic [EXP_W-1:0]  s2_exp
);
  logic [FRAC_W-1:0] aligned;
  logic [FRAC_W:0]   raw;
  logic              raw_sign;

  always_comb begin
    if (32'(shift_t) >= 32'(FRAC_W)) aligned = '0;
    else                             aligned = sml_frac >> shift_t;

    if (big_sign == sml_sign) begin
      raw      = {1'b0, big_frac} + {1'b0, aligned};
      raw_sign = big_sign;
    end else if (big_frac >= aligned) begin
      raw      = {1'b0, big_frac} - {1'b0, aligned};
      raw_sign = big_sign;
    end else begin
      raw      = {1'b0, aligned} - {1'b0, big_frac};
      raw_sign = sml_sign;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else     s2_valid <= s1_valid;
    c_sign <= raw_sign;
    c_mag  <= raw;
    s2_exp <= exp_r;
  end
endmodule

// File: rtl/fpadd_lzc.sv
module fpadd_lzc
  import fpadd_pkg::*;
#(
  parameter int FRAC_W = 8,
  parameter int EXP_W  = 6,
  localparam int LZ_W  = $clog2(FRAC_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s2_valid,
  input  logic              c_sign,
  input  logic [FRAC_W:0]   c_mag,
  input  logic [EXP_W-1:0]  s2_exp,
  output logic              s3_valid,
  output logic              s3_sign,
  output logic [FRAC_W:0]   s3_mag,
  output logic [EXP_W-1:0]  s3_exp,
  output logic [LZ_W-1:0]   s3_lz,
  output res_kind_e         s3_kind
);
  logic [LZ_W-1:0] lz;
  logic            found;
  res_kind_e       kind;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = FRAC_W - 1; i >= 0; i--) begin
      if (!found && c_mag[i]) begin
        lz    = LZ_W'(FRAC_W - 1 - i);
        found = 1'b1;
      end
    end
    if (c_mag == '0)      kind = RES_ZERO;
    else if (c_mag[FRAC_W]) kind = RES_CARRY;
    else                  kind = RES_NORM;
  end

  always_ff @(posedge clk) begin
    if (rst) s3_valid <= 1'b0;
    else     s3_valid <= s2_valid;
    s3_sign <= c_sign;
    s3_mag  <= c_mag;
    s3_exp  <= s2_exp;
    s3_lz   <= lz;
    s3_kind <= kind;
  end
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
  import fpadd_pkg::*;
#(
  parameter int FRAC_W = 8,
  parameter int EXP_W  = 6,
  localparam int LZ_W  = $clog2(FRAC_W + 1),
  localparam int OE_W  = EXP_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s3_valid,
  input  logic              s3_sign,
  input  logic [FRAC_W:0]   s3_mag,
  input  logic [EXP_W-1:0]  s3_exp,
  input  logic [LZ_W-1:0]   s3_lz,
  input  res_kind_e         s3_kind,
  output logic              out_valid,
  output logic              out_sign,
  output logic [FRAC_W-1:0] out_frac,
  output logic [OE_W-1:0]   out_exp
);
  logic [OE_W-1:0]   r_ext;
  logic [OE_W-1:0]   n_exp;
  logic [FRAC_W-1:0] n_frac;
  logic              n_sign;

  always_comb begin
    r_ext = {{2{s3_exp[EXP_W-1]}}, s3_exp};
    unique case (s3_kind)
      RES_ZERO: begin
        n_frac = '0;
        n_exp  = '0;
        n_sign = 1'b0;
      end
      RES_CARRY: begin
        n_frac = s3_mag[FRAC_W:1];
        n_exp  = r_ext + OE_W'(1);
        n_sign = s3_sign;
      end
      default: begin
        n_frac = s3_mag[FRAC_W-1:0] << s3_lz;
        n_exp  = r_ext - OE_W'(s3_lz);
        n_sign = s3_sign;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s3_valid;
    out_sign <= n_sign;
    out_frac <= n_frac;
    out_exp  <= n_exp;
  end
endmodule

// File: rtl/fpadd_pipe.sv
module fpadd_pipe
  import fpadd_pkg::*;
#(
  parameter int FRAC_W = 8,
  parameter int EXP_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              a_sign,
  input  logic [FRAC_W-1:0] a_frac,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic              b_sign,
  input  logic [FRAC_W-1:0] b_frac,
  input  logic [EXP_W-1:0]  b_exp,
  output logic              out_valid,
  output logic              out_sign,
  output logic [FRAC_W-1:0] out_frac,
  output logic [EXP_W+1:0]  out_exp
);
  localparam int LZ_W = $clog2(FRAC_W + 1);

  logic              s1_valid, big_sign, sml_sign;
  logic [FRAC_W-1:0] big_frac, sml_frac;
  logic [EXP_W-1:0]  exp_r, shift_t;

  logic              s2_valid, c_sign;
  logic [FRAC_W:0]   c_mag;
  logic [EXP_W-1:0]  s2_exp;

  logic              s3_valid, s3_sign;
  logic [FRAC_W:0]   s3_mag;
  logic [EXP_W-1:0]  s3_exp;
  logic [LZ_W-1:0]   s3_lz;
  res_kind_e         s3_kind;

  fpadd_cmp #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_cmp (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_sign(a_sign), .a_frac(a_frac), .a_exp(a_exp),
    .b_sign(b_sign), .b_frac(b_frac), .b_exp(b_exp),
    .s1_valid(s1_valid), .big_sign(big_sign), .big_frac(big_frac),
    .sml_sign(sml_sign), .sml_frac(sml_frac), .exp_r(exp_r), .shift_t(shift_t)
  );

  fpadd_align #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_align (
    .clk(clk), .rst(rst), .s1_valid(s1_valid),
    .big_sign(big_sign), .big_frac(big_frac),
    .sml_sign(sml_sign), .sml_frac(sml_frac),
    .exp_r(exp_r), .shift_t(shift_t),
    .s2_valid(s2_valid), .c_sign(c_sign), .c_mag(c_mag), .s2_exp(s2_exp)
  );

  fpadd_lzc #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_lzc (
    .clk(clk), .rst(rst), .s2_valid(s2_valid),
    .c_sign(c_sign), .c_mag(c_mag), .s2_exp(s2_exp),
    .s3_valid(s3_valid), .s3_sign(s3_sign), .s3_mag(s3_mag),
    .s3_exp(s3_exp), .s3_lz(s3_lz), .s3_kind(s3_kind)
  );

  fpadd_norm #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_norm (
    .clk(clk), .rst(rst), .s3_valid(s3_valid),
    .s3_sign(s3_sign), .s3_mag(s3_mag), .s3_exp(s3_exp),
    .s3_lz(s3_lz), .s3_kind(s3_kind),
    .out_valid(out_valid), .out_sign(out_sign),
    .out_frac(out_frac), .out_exp(out_exp)
  );
endmodule

// File: rtl/fpadd_pipe_chk.sv
module fpadd_pipe_chk #(
  parameter int FRAC_W = 8,
  parameter int EXP_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              a_sign,
  input logic              b_sign,
  input logic              out_valid,
  input logic              out_sign,
  input logic [FRAC_W-1:0] out_frac,
  input logic [EXP_W+1:0]  out_exp
);
  localparam int EMAX = 2 ** (EXP_W - 1);
  localparam int EMIN = -EMAX - (FRAC_W - 1);

  logic [2:0] warm;

  always_ff @(posedge clk) begin
    if (rst)               warm <= 3'd0;
    else if (warm != 3'd4) warm <= warm + 3'd1;
  end

  // R2
  p_flush_r2: assert property (@(posedge clk) rst |=> !out_valid);

  // R1
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (warm == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // R4
  p_same_sign_r4: assert property (@(posedge clk) disable iff (rst)
    (warm == 3'd4 && out_valid && out_frac != '0 &&
     $past(a_sign, 4) == $past(b_sign, 4)) |-> (out_sign == $past(a_sign, 4)));

  // R7
  p_normalized_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_frac != '0) |-> out_frac[FRAC_W-1]);

  // R8
  p_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_frac == '0) |-> (!out_sign && out_exp == '0));

  // R9
  p_exp_range_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(out_exp) <= EMAX && $signed(out_exp) >= EMIN));
endmodule

bind fpadd_pipe fpadd_pipe_chk #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .a_sign(a_sign), .b_sign(b_sign),
  .out_valid(out_valid), .out_sign(out_sign),
  .out_frac(out_frac), .out_exp(out_exp)
);

// File: tb/tb_fpadd_pipe.sv
module tb_fpadd_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 4;
  localparam int EW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          a_sign = 1'b0, b_sign = 1'b0;
  logic [FW-1:0] a_frac = '0, b_frac = '0;
  logic [EW-1:0] a_exp = '0, b_exp = '0;
  logic          out_valid, out_sign;
  logic [FW-1:0] out_frac;
  logic [EW+1:0] out_exp;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  bit  hv[4];
  int  hs[4], hf[4], he[4], hk[4];
  bit  hdiff[4], hout[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  fpadd_pipe #(.FRAC_W(FW), .EXP_W(EW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_sign(a_sign), .a_frac(a_frac), .a_exp(a_exp),
    .b_sign(b_sign), .b_frac(b_frac), .b_exp(b_exp),
    .out_valid(out_valid), .out_sign(out_sign),
    .out_frac(out_frac), .out_exp(out_exp)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // kind: 0 ordinary, 1 carry-out, 2 zero
  task automatic model(input int sa, input int ma, input int ea,
                       input int sb, input int mb, input int eb,
                       output int rs, output int rf, output int re,
                       output int rk, output bit shifted_out);
    int r, t, bm, bs, sm, ss, al, sum, mag;
    if (ea >= eb) begin r = ea; t = ea - eb; bm = ma; bs = sa; sm = mb; ss = sb; end
    else          begin r = eb; t = eb - ea; bm = mb; bs = sb; sm = ma; ss = sa; end
    shifted_out = (t >= FW) && (sm != 0);
    al  = (t >= FW) ? 0 : (sm >> t);
    sum = (bs != 0 ? -bm : bm) + (ss != 0 ? -al : al);
    rs  = (sum < 0) ? 1 : 0;
    mag = (sum < 0) ? -sum : sum;
    if (mag == 0) begin
      rs = 0; rf = 0; re = 0; rk = 2;
    end else if (mag >= (1 << FW)) begin
      rf = mag / 2; re = r + 1; rk = 1;
    end else begin
      re = r;
      while (mag < (1 << (FW - 1))) begin
        mag = mag * 2;
        re  = re - 1;
      end
      rf = mag; rk = 0;
    end
  endtask

  task automatic step(input bit v, input logic [7:0] ca, input logic [7:0] cb);
    string ft, et;
    if (hv[3]) begin
      chk(out_valid === 1'b1, "R1 result valid", int'(out_valid), 1);
      ft = (hk[3] == 2) ? "R8 zero fraction" : (hk[3] == 1) ? "R6 carry fraction" :
           hout[3] ? "R3 aligned-out fraction" : "R7 normalized fraction";
      chk(int'(out_frac) == hf[3], ft, int'(out_frac), hf[3]);
      et = (hk[3] == 2) ? "R8 zero exponent" : (hk[3] == 1) ? "R6 carry exponent" :
           (he[3] < -(2 ** (EW - 1))) ? "R9 extended exponent" : "R7 exponent";
      chk(int'($signed(out_exp)) == he[3], et, int'($signed(out_exp)), he[3]);
      chk(int'(out_sign) == hs[3], hdiff[3] ? "R5 sign" : "R4 sign", int'(out_sign), hs[3]);
    end else begin
      chk(out_valid === 1'b0, "R1 idle slot", int'(out_valid), 0);
    end
    for (int i = 3; i > 0; i--) begin
      hv[i] = hv[i-1]; hs[i] = hs[i-1]; hf[i] = hf[i-1]; he[i] = he[i-1];
      hk[i] = hk[i-1]; hdiff[i] = hdiff[i-1]; hout[i] = hout[i-1];
    end
    hv[0] = v;
    if (v) begin
      model(int'(ca[7]), int'(ca[3:0]), int'($signed(ca[6:4])),
            int'(cb[7]), int'(cb[3:0]), int'($signed(cb[6:4])),
            hs[0], hf[0], he[0], hk[0], hout[0]);
      hdiff[0] = ca[7] != cb[7];
    end
    in_valid = v;
    a_sign = ca[7]; a_exp = ca[6:4]; a_frac = ca[3:0];
    b_sign = cb[7]; b_exp = cb[6:4]; b_frac = cb[3:0];
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) hv[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R2 reset state", int'(out_valid), 0);
    rst = 1'b0;
    // R10 encoding: code = {sign, exp[2:0], magnitude[3:0]}
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) step(1'b1, 8'(a), 8'(b));
      step(1'b0, 8'h00, 8'h00);
    end
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 8'h00);
    // R2: reset with a full pipeline
    in_valid = 1'b1; a_frac = 4'd9; b_frac = 4'd3;
    repeat (3) @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk(out_valid === 1'b0, "R2 flushed pipeline", int'(out_valid), 0);
      @(negedge clk);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule